// File: doc/BRIEF.md
# Scan-Driven Debug Register Access Controller

This block gives a debugger reached through a four-wire scan port (TCK, TMS, TDI, TDO, plus an active-low test reset) read and write access to up to 128 client registers of 32 bits each. It contains a complete 16-state scan state machine, a 4-bit instruction register and a three-state access sequencer. The sequencer layers register accesses on top of ordinary data-register scans.

Once the debug-enable instruction (opcode 4'b0111) is loaded, every register access takes two data scans. The first scan shifts in an 8-bit command that names the register and says whether it is a read or a write. The second scan moves 32 bits of data. A read fetches the register at CAPTURE-DR and shifts its value out. A write shifts the value in and commits it at UPDATE-DR. The client side is a simple port that runs in the TCK domain, with a one-cycle read strobe and a one-cycle write strobe.

Top module: `dbg_reg_access`

## Requirements
- R1: When trst_n is low at a rising TCK edge, the block enters TEST-LOGIC-RESET. Entering TEST-LOGIC-RESET loads BYPASS (4'b1111) into the instruction register and returns the sequencer to idle. After reset, tdo_en is 0 and neither client strobe fires.
- R2: The instruction register is 4 bits wide and shifts LSB first. CAPTURE-IR loads 4'b0001, so an IR scan shifts out 1,0,0,0. The enable opcode is 4'b0111.
- R3: With any instruction other than the enable opcode, the data path is a 1-bit bypass stage that captures 0. An N-bit DR scan therefore returns 0 followed by the input delayed by one bit.
- R4: With the enable opcode loaded, the next DR scan is an 8-bit command, shifted LSB first. Bit 0 is the direction (1 = write, 0 = read) and bits 7:1 are the register index. The command scan shifts out zeros.
- R5: A data scan after a write command is 32 bits, LSB first, and shifts out zeros. In UPDATE-DR it raises client_wr_en for exactly one cycle, with client_addr set to the index and client_wdata set to the shifted value.
- R6: A data scan after a read command raises client_rd_en for exactly one cycle, in CAPTURE-DR. The captured client_rdata is shifted out LSB first, and client_wr_en stays low.
- R7: After each data scan, the next DR scan is treated as a new command, so command and data scans alternate indefinitely.
- R8: An UPDATE-IR that loads any non-enable opcode returns the sequencer to idle. Later DR scans act as bypass and produce no client strobes.
- R9: TDO is updated on the falling edge of TCK. tdo_en is 1 only while in SHIFT-IR or SHIFT-DR, and tdo is 0 whenever tdo_en is 0.
- R10: Five consecutive rising edges with TMS high reach TEST-LOGIC-RESET from any state, with the same effects as R1. A pending command is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Active-low test reset, sampled on rising TCK |
| tms | input | 1 | Mode select steering the scan state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling TCK |
| tdo_en | output | 1 | High while tdo carries shift data |
| client_addr | output | 7 | Index of the addressed client register |
| client_wr_en | output | 1 | One-cycle write strobe |
| client_wdata | output | 32 | Write value |
| client_rd_en | output | 1 | One-cycle read strobe |
| client_rdata | input | 32 | Read value of the addressed register, valid in the strobe cycle |

## Verification
The bench tests access pairs at random indices and with random values. It mixes these with directed accesses at the lowest and highest index, so address-bit and data-bit mistakes become visible when values are read back. Bypass scans with random patterns separate the 1-bit delay path from the command and data paths. Scans after an unknown opcode, and after a reset taken between a command and its data scan, show that the sequencer really abandons its state rather than corrupting a register. Strobe counts per access separate reads from writes and expose any duplicate or missing strobe.

// File: rtl/dbgacc_pkg.sv
// Shared types for the debug register access controller.
// Assumes: a standard 16-state scan controller and a three-state access sequencer.
package dbgacc_pkg;

    typedef enum logic [3:0] {
        TS_TLR, TS_RTI,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SELECT,
        SQ_ACCESS
    } seq_state_e;

endpackage

// File: rtl/dbgacc_tap.sv
// Scan state machine: walks the 16 standard states on TMS at each rising TCK.
// Assumes: trst_n is synchronous and active low; reset lands in TEST-LOGIC-RESET.
module dbgacc_tap
    import dbgacc_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_nx;

    // Next state from the current state and TMS.
    always_comb begin
        unique case (state)
            TS_TLR:    state_nx = tms ? TS_TLR    : TS_RTI;
            TS_RTI:    state_nx = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_DR: state_nx = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: state_nx = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: state_nx = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_nx = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_nx = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: state_nx = tms ? TS_SEL_DR : TS_RTI;
            TS_SEL_IR: state_nx = tms ? TS_TLR    : TS_CAP_IR;
            TS_CAP_IR: state_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: state_nx = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: state_nx = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_nx = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_nx = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: state_nx = tms ? TS_SEL_DR : TS_RTI;
            default:   state_nx = TS_TLR;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= TS_TLR;
        else         state <= state_nx;
    end

    // R10: five rising edges with TMS high always end in TEST-LOGIC-RESET.
    a_r10_five_ones_reset: assert property (@(posedge tck) disable iff (!trst_n)
        ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
        |-> (state == TS_TLR));

endmodule

// File: rtl/dbgacc_ir.sv
// Instruction register: captures a fixed pattern, shifts LSB first and loads on UPDATE-IR.
// Assumes: all-ones is BYPASS; en_next tells the sequencer that the pending opcode is the enable one.
module dbgacc_ir
    import dbgacc_pkg::*;
#(
    parameter int              IR_W      = 4,
    parameter logic [IR_W-1:0] EN_OPCODE = 4'b0111
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e tap_state,
    input  logic       tdi,
    output logic       ir_so,
    output logic       en_next
);

    localparam logic [IR_W-1:0] BYPASS_OP = '1;
    localparam logic [IR_W-1:0] CAP_PAT   = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    assign ir_so   = ir_sr[0];
    assign en_next = (ir_sr == EN_OPCODE);

    // Shift stage: capture a fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                    ir_sr <= '0;
        else if (tap_state == TS_CAP_IR) ir_sr <= CAP_PAT;
        else if (tap_state == TS_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Holding register: BYPASS after reset, new opcode on UPDATE-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || tap_state == TS_TLR) ir_q <= BYPASS_OP;
        else if (tap_state == TS_UPD_IR)    ir_q <= ir_sr;
    end

    // R1: a cycle in TEST-LOGIC-RESET leaves BYPASS loaded.
    a_r1_tlr_bypass: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_TLR) |=> (ir_q == BYPASS_OP));

    // R2: after UPDATE-IR the holding register matches what was shifted in.
    a_r2_update_loads: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_UPD_IR) |=> (ir_q == $past(ir_sr)));

endmodule

// File: rtl/dbgacc_seq.sv
// Access sequencer and data registers: the bypass bit, the command shifter and the data shifter.
// Assumes: non-idle only while the enable opcode is loaded; client_rdata is valid in the
// same cycle as client_rd_en.
module dbgacc_seq
    import dbgacc_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_e        tap_state,
    input  logic              tdi,
    input  logic              en_next,
    input  logic [DATA_W-1:0] client_rdata,
    output logic              dr_so,
    output logic [IDX_W-1:0]  client_addr,
    output logic              client_wr_en,
    output logic [DATA_W-1:0] client_wdata,
    output logic              client_rd_en
);

    localparam int CMD_W = IDX_W + 1;

    seq_state_e        seq;
    logic              byp_bit;
    logic [CMD_W-1:0]  cmd_sr;
    logic [DATA_W-1:0] data_sr;
    logic [IDX_W-1:0]  cmd_idx;
    logic              cmd_wr;

    // Strobes are decoded from the scan state and the latched command.
    assign client_rd_en = (tap_state == TS_CAP_DR) && (seq == SQ_ACCESS) && !cmd_wr;
    assign client_wr_en = (tap_state == TS_UPD_DR) && (seq == SQ_ACCESS) && cmd_wr;
    assign client_addr  = cmd_idx;
    assign client_wdata = data_sr;

    // Serial output picked by the sequencer state.
    always_comb begin
        unique case (seq)
            SQ_SELECT: dr_so = cmd_sr[0];
            SQ_ACCESS: dr_so = data_sr[0];
            default:   dr_so = byp_bit;
        endcase
    end

    // Sequencer: the enable opcode opens it, each UPDATE-DR toggles command/data.
    always_ff @(posedge tck) begin
        if (!trst_n || tap_state == TS_TLR) begin
            seq <= SQ_IDLE;
        end else if (tap_state == TS_UPD_IR) begin
            seq <= en_next ? SQ_SELECT : SQ_IDLE;
        end else if (tap_state == TS_UPD_DR) begin
            if (seq == SQ_SELECT)      seq <= SQ_ACCESS;
            else if (seq == SQ_ACCESS) seq <= SQ_SELECT;
        end
    end

    // Bypass stage: captures 0 and delays the input by one bit.
    always_ff @(posedge tck) begin
        if (!trst_n)                     byp_bit <= 1'b0;
        else if (tap_state == TS_CAP_DR) byp_bit <= 1'b0;
        else if (tap_state == TS_SHF_DR) byp_bit <= tdi;
    end

    // Command shifter: clears on capture, shifts only in the select phase.
    always_ff @(posedge tck) begin
        if (!trst_n)
            cmd_sr <= '0;
        else if (seq == SQ_SELECT && tap_state == TS_CAP_DR)
            cmd_sr <= '0;
        else if (seq == SQ_SELECT && tap_state == TS_SHF_DR)
            cmd_sr <= {tdi, cmd_sr[CMD_W-1:1]};
    end

    // Command latch: index and direction taken when the command scan completes.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            cmd_idx <= '0;
            cmd_wr  <= 1'b0;
        end else if (seq == SQ_SELECT && tap_state == TS_UPD_DR) begin
            cmd_idx <= cmd_sr[CMD_W-1:1];
            cmd_wr  <= cmd_sr[0];
        end
    end

    // Data shifter: loads read data (or zero for writes) on capture, shifts in the access phase.
    always_ff @(posedge tck) begin
        if (!trst_n)
            data_sr <= '0;
        else if (seq == SQ_ACCESS && tap_state == TS_CAP_DR)
            data_sr <= cmd_wr ? '0 : client_rdata;
        else if (seq == SQ_ACCESS && tap_state == TS_SHF_DR)
            data_sr <= {tdi, data_sr[DATA_W-1:1]};
    end

    // R5: the write strobe never lasts two cycles.
    a_r5_wr_single: assert property (@(posedge tck) disable iff (!trst_n)
        client_wr_en |=> !client_wr_en);

    // R6: the read strobe never lasts two cycles and never overlaps a write.
    a_r6_rd_single: assert property (@(posedge tck) disable iff (!trst_n)
        client_rd_en |=> !client_rd_en);
    a_r6_no_overlap: assert property (@(posedge tck) disable iff (!trst_n)
        !(client_rd_en && client_wr_en));

    // R7: command completion moves to the data phase, data completion back to select.
    a_r7_cmd_to_data: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_UPD_DR && seq == SQ_SELECT) |=> (seq == SQ_ACCESS));
    a_r7_data_to_cmd: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_UPD_DR && seq == SQ_ACCESS) |=> (seq == SQ_SELECT));

    // R8: loading another opcode closes the sequencer.
    a_r8_other_ir_idle: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == TS_UPD_IR && !en_next) |=> (seq == SQ_IDLE));

endmodule

// File: rtl/dbg_reg_access.sv
// Top level: scan state machine, instruction register, access sequencer and the
// falling-edge TDO stage.
// Assumes: the client register file runs on TCK and answers reads combinationally.
module dbg_reg_access
    import dbgacc_pkg::*;
#(
    parameter int              IR_W      = 4,
    parameter logic [IR_W-1:0] EN_OPCODE = 4'b0111,
    parameter int              IDX_W     = 7,
    parameter int              DATA_W    = 32
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_en,
    output logic [IDX_W-1:0]  client_addr,
    output logic              client_wr_en,
    output logic [DATA_W-1:0] client_wdata,
    output logic              client_rd_en,
    input  logic [DATA_W-1:0] client_rdata
);

    tap_state_e tap_state;
    logic       ir_so;
    logic       dr_so;
    logic       en_next;
    logic       in_shift;

    dbgacc_tap u_tap (
        .tck   (tck),
        .trst_n(trst_n),
        .tms   (tms),
        .state (tap_state)
    );

    dbgacc_ir #(
        .IR_W     (IR_W),
        .EN_OPCODE(EN_OPCODE)
    ) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tap_state(tap_state),
        .tdi      (tdi),
        .ir_so    (ir_so),
        .en_next  (en_next)
    );

    dbgacc_seq #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W)
    ) u_seq (
        .tck         (tck),
        .trst_n      (trst_n),
        .tap_state   (tap_state),
        .tdi         (tdi),
        .en_next     (en_next),
        .client_rdata(client_rdata),
        .dr_so       (dr_so),
        .client_addr (client_addr),
        .client_wr_en(client_wr_en),
        .client_wdata(client_wdata),
        .client_rd_en(client_rd_en)
    );

    assign in_shift = (tap_state == TS_SHF_IR) || (tap_state == TS_SHF_DR);

    // Output stage on falling TCK: drive shift data, hold 0 elsewhere.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= in_shift;
            tdo    <= (tap_state == TS_SHF_IR) ? ir_so :
                      (tap_state == TS_SHF_DR) ? dr_so : 1'b0;
        end
    end

    // R9: tdo is quiet whenever it is not enabled.
    a_r9_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_en |-> !tdo);

    // R9: the enable is only seen while a shift state is current.
    a_r9_en_in_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> in_shift);

endmodule

// File: tb/dbg_reg_access_tb.sv
// Bench: acts as scan master and client register file, checks against a shadow model.
module dbg_reg_access_tb;

    localparam int CLK_PERIOD = 10;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        tdo_en;
    logic [6:0]  client_addr;
    logic        client_wr_en;
    logic [31:0] client_wdata;
    logic        client_rd_en;
    logic [31:0] client_rdata;

    logic [31:0] mem    [128];
    logic [31:0] shadow [128];
    int n_chk = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) tck = ~tck;

    dbg_reg_access u_dut (
        .tck         (tck),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .tdo         (tdo),
        .tdo_en      (tdo_en),
        .client_addr (client_addr),
        .client_wr_en(client_wr_en),
        .client_wdata(client_wdata),
        .client_rd_en(client_rd_en),
        .client_rdata(client_rdata)
    );

    // Client register file as seen by the block.
    assign client_rdata = mem[client_addr];
    always @(posedge tck) begin
        if (client_wr_en) begin
            mem[client_addr] <= client_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (client_rd_en) rd_cnt <= rd_cnt + 1;
    end

    function automatic logic [63:0] bypass_out(input logic [63:0] din);
        return {din[62:0], 1'b0};
    endfunction

    function automatic logic [63:0] cmd_word(input logic [6:0] idx, input bit wr);
        return {56'd0, idx, wr};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One TCK cycle: sample tdo after the falling edge, then drive the inputs.
    task automatic step(input bit tms_v, input bit tdi_v, output bit tdo_v, output bit en_v);
        @(negedge tck);
        #1;
        tdo_v = tdo;
        en_v  = tdo_en;
        tms   = tms_v;
        tdi   = tdi_v;
        @(posedge tck);
    endtask

    // Full scan from RUN-TEST/IDLE back to RUN-TEST/IDLE; checks the output enable (R9).
    task automatic scan(input bit is_ir, input int n, input logic [63:0] din, output logic [63:0] dout);
        bit b, e;
        bit en_ok = 1'b1;
        dout = '0;
        step(1, 0, b, e);
        if (is_ir) step(1, 0, b, e);
        step(0, 0, b, e);
        step(0, 0, b, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], b, e);
            dout[i] = b;
            if (!e) en_ok = 1'b0;
        end
        step(1, 0, b, e);
        if (e) en_ok = 1'b0;
        step(0, 0, b, e);
        step(0, 0, b, e);
        chk(en_ok && !e && !b, "R9 tdo_en only in shift", {62'd0, e, b}, 64'd0);
    endtask

    task automatic tms_reset();
        bit b, e;
        for (int i = 0; i < 5; i++) step(1, 0, b, e);
        step(0, 0, b, e);
    endtask

    task automatic do_write(input logic [6:0] idx, input logic [31:0] val);
        logic [63:0] d;
        int w0;
        w0 = wr_cnt;
        scan(0, 8, cmd_word(idx, 1), d);
        chk(d[7:0] == 8'h00, "R4 command scan out zero", d, 64'd0);
        scan(0, 32, {32'd0, val}, d);
        chk(d[31:0] == 32'd0, "R5 write scan out zero", d, 64'd0);
        chk(wr_cnt == w0 + 1, "R5 one write strobe", wr_cnt, w0 + 1);
        shadow[idx] = val;
    endtask

    task automatic do_read(input logic [6:0] idx, output logic [31:0] val);
        logic [63:0] d;
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        scan(0, 8, cmd_word(idx, 0), d);
        scan(0, 32, {32'd0, $urandom}, d);
        val = d[31:0];
        chk(rd_cnt == r0 + 1 && wr_cnt == w0, "R6 one read strobe, no write",
            {rd_cnt, wr_cnt}, {r0 + 1, w0});
    endtask

    task automatic check_read(input logic [6:0] idx, input string req);
        logic [31:0] v;
        do_read(idx, v);
        chk(v == shadow[idx], req, v, shadow[idx]);
    endtask

    task automatic load_ir(input logic [3:0] op);
        logic [63:0] d;
        scan(1, 4, {60'd0, op}, d);
        chk(d[3:0] == 4'b0001, "R2 IR capture pattern", d[3:0], 4'b0001);
    endtask

    task automatic check_bypass(input string req);
        logic [63:0] din, d;
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        din = {32'd0, $urandom} & 64'hFFFF;
        scan(0, 16, din, d);
        chk(d[15:0] == bypass_out(din)[15:0], req, d[15:0], bypass_out(din)[15:0]);
        chk(wr_cnt == w0 && rd_cnt == r0, req, {rd_cnt, wr_cnt}, {r0, w0});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [31:0] v;
        bit b, e;
        void'($urandom(32'h1F2E_3D4C));
        for (int i = 0; i < 128; i++) begin
            mem[i]    = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
            shadow[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
        end

        // R1: reset state
        repeat (3) @(posedge tck);
        @(negedge tck);
        trst_n = 1'b1;
        tms    = 1'b0;
        step(0, 0, b, e);
        chk(!e && !b && wr_cnt == 0 && rd_cnt == 0, "R1 quiet after reset", {e, b}, 0);
        check_bypass("R1 R3 bypass after reset");

        // R2/R4/R5/R6: enable, then directed corner indices
        load_ir(4'b0111);
        do_write(7'd0, 32'hDEAD_BEEF);
        do_write(7'd127, 32'h8000_0001);
        check_read(7'd0, "R6 read index 0");
        check_read(7'd127, "R6 read index 127");
        chk(mem[0] == 32'hDEAD_BEEF && mem[127] == 32'h8000_0001, "R5 client written",
            {mem[0], mem[127]}, {32'hDEAD_BEEF, 32'h8000_0001});

        // R7: random sequence of alternating command/data pairs
        for (int k = 0; k < 30; k++) begin
            logic [6:0] idx;
            idx = 7'($urandom_range(0, 127));
            if ($urandom_range(0, 1) == 1) do_write(idx, $urandom);
            else check_read(idx, "R7 random read");
        end
        begin
            int bad = 0;
            for (int i = 0; i < 128; i++) if (mem[i] !== shadow[i]) bad++;
            chk(bad == 0, "R6 R7 registers match model", bad, 0);
        end

        // R8: another opcode closes access
        load_ir(4'b0011);
        check_bypass("R8 bypass after other opcode");
        check_bypass("R8 no strobes after other opcode");

        // R10: TMS reset between command and data scans abandons the write
        load_ir(4'b0111);
        scan(0, 8, cmd_word(7'd5, 1), d);
        tms_reset();
        step(0, 0, b, e);
        chk(!e && !b, "R10 quiet after TMS reset", {e, b}, 0);
        check_bypass("R10 bypass after TMS reset");
        load_ir(4'b0111);
        check_read(7'd5, "R10 pending write abandoned");

        // R1: trst_n between command and data scans
        scan(0, 8, cmd_word(7'd9, 1), d);
        @(negedge tck);
        trst_n = 1'b0;
        repeat (2) @(posedge tck);
        @(negedge tck);
        trst_n = 1'b1;
        step(0, 0, b, e);
        check_bypass("R1 bypass after trst_n");
        load_ir(4'b0111);
        check_read(7'd9, "R1 pending write abandoned");
        do_write(7'd9, 32'h0F0F_1234);
        do_read(7'd9, v);
        chk(v == 32'h0F0F_1234, "R4 R7 access after re-enable", v, 32'h0F0F_1234);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule